// File: doc/BRIEF.md
# Per-Core Open Row Shadow Tracker

This block sits beside the DRAM scheduler in a memory controller. It keeps, for every core, a private record of the row that core last used in each bank. This record shows what the row buffers would hold if the core ran alone on the machine. On each DRAM access the controller reports:

- which core issued the access;
- the target bank and row;
- whether the real access hit the open row;
- the MSHR slot the access belongs to.

Some accesses are real row-buffer misses that would have been row hits in isolation. For those, the tracker issues a one-cycle charge strobe. The strobe carries the extra row-miss latency and the MSHR slot, so the waiting-cycle counter of that slot can absorb the cost of the interference.

The extra latency is the precharge time plus the activate-to-column time. With the default 9-9-9-7 timing this is 18 memory cycles. The tracker is only meaningful under an open-page policy. When the controller runs closed-page, the tracker is idle: it neither charges nor learns.

Top module: `row_shadow_tracker`

## Requirements
- R1: After reset `pen_valid` is 0 and every shadow entry is empty. An access that finds an empty entry is never charged, even if it is a real row miss.
- R2: An accepted access is charged when `open_page` is 1, `acc_row_hit` is 0, and the shadow entry of the issuing core for the target bank is valid and equals `acc_row`. In the clock cycle after the access, `pen_valid` is 1, `pen_cycles` equals T_RP+T_RCD (18 by default), and `pen_mshr` equals the access's `acc_mshr`.
- R3: An access reported as a real row hit (`acc_row_hit`=1) is never charged.
- R4: A real row miss to a row that differs from the core's shadow row for that bank is not charged.
- R5: In open-page mode, every accepted access replaces the issuing core's shadow entry for the target bank with `acc_row`, whether the access hit or missed. The new value applies from the next cycle.
- R6: An access by one core never changes the shadow entries of any other core.
- R7: With `open_page`=0 (closed-page policy), no access is charged and no shadow entry changes.
- R8: `pen_valid` is 1 only in the cycle that follows an accepted access (`acc_valid`=1). With no access it is 0.
- R9: The shadow entries of the different banks of one core are independent. An access to one bank never changes the entry of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| open_page | input | 1 | 1 = open-page policy (tracker active), 0 = closed-page |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_core | input | CORE_W | Issuing core |
| acc_bank | input | BANK_W | Target bank |
| acc_row | input | ROW_W | Target row |
| acc_row_hit | input | 1 | The real access hit the open row |
| acc_mshr | input | MSHR_W | MSHR slot of the access |
| pen_valid | output | 1 | One-cycle charge strobe |
| pen_cycles | output | PEN_W | Waiting cycles to add |
| pen_mshr | output | MSHR_W | MSHR slot to charge |

## Verification
The bench sweeps every core and bank and goes after the corner cases below. Each case names the fault it would expose.

- **First access to an empty entry.** This catches a design that compares against reset garbage.
- **Real hit to a recorded row.** A design that ignores `acc_row_hit` would charge here.
- **Another core overwriting the same bank.** A design that shares entries across cores would lose the core's private row here.
- **Update after a hit.** A design that learns only on misses would miss a later charge.
- **A closed-page window between two open-page accesses.** A design that keeps learning while disabled would fail to charge afterward.

Each charge is checked for its value and MSHR slot, and every non-charge is checked for a silent strobe. Together these catch a wrong latency sum or a misrouted slot.

// File: rtl/orow_pkg.sv
// Package: shared encodings for the open row shadow tracker.
// Assumes: the page policy is a single bit driven by the controller.
package orow_pkg;
    typedef enum logic {
        PAGE_CLOSED = 1'b0,
        PAGE_OPEN   = 1'b1
    } page_policy_e;
endpackage

// File: rtl/orow_bank_table.sv
// Module: shadow row storage for a single core, one entry per bank.
// Assumes: at most one write per cycle; the read is combinational and
// returns the value stored before the current cycle's write.
module orow_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 20,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  wr_row,
    output logic              rd_valid,
    output logic [ROW_W-1:0]  rd_row
);
    logic [NUM_BANKS-1:0] vld_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    // Valid bits: cleared by reset, set on the first write to a bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en)
            vld_q[bank] <= 1'b1;
    end

    // Row storage: holds the last row written for each bank.
    always_ff @(posedge clk) begin
        if (wr_en)
            row_q[bank] <= wr_row;
    end

    // Read port: entry for the bank addressed this cycle.
    always_comb begin
        rd_valid = vld_q[bank];
        rd_row   = row_q[bank];
    end
endmodule

// File: rtl/orow_classifier.sv
// Module: decides whether a real row miss was caused by another core.
// Assumes: entry inputs hold the issuing core's shadow before the update.
module orow_classifier #(
    parameter int ROW_W = 20
) (
    input  logic             acc_valid,
    input  logic             policy_open,
    input  logic             row_hit,
    input  logic             entry_valid,
    input  logic [ROW_W-1:0] entry_row,
    input  logic [ROW_W-1:0] acc_row,
    output logic             interfere
);
    // Interference: a real miss where isolation would have hit.
    always_comb begin
        interfere = acc_valid && policy_open && !row_hit &&
                    entry_valid && (entry_row == acc_row);
    end
endmodule

// File: rtl/orow_penalty_reg.sv
// Module: registers the charge strobe together with its value and slot.
// Assumes: the penalty value is a constant fixed by the timing parameters.
module orow_penalty_reg #(
    parameter int MSHR_W = 4,
    parameter int PEN_W  = 8,
    parameter int PEN    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [MSHR_W-1:0] mshr_in,
    output logic              pen_valid,
    output logic [PEN_W-1:0]  pen_cycles,
    output logic [MSHR_W-1:0] pen_mshr
);
    localparam logic [PEN_W-1:0] PEN_VAL = PEN_W'(PEN);

    // Strobe: high for exactly the cycle after a classified access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pen_valid <= 1'b0;
        else
            pen_valid <= fire;
    end

    // Payload: value and MSHR slot are captured with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_cycles <= '0;
            pen_mshr   <= '0;
        end else if (fire) begin
            pen_cycles <= PEN_VAL;
            pen_mshr   <= mshr_in;
        end
    end
endmodule

// File: rtl/row_shadow_tracker.sv
// Module: top of the per-core open row shadow tracker.
// Keeps one shadow table per core and charges row misses that another
// core caused. Assumes acc_core values at or above NUM_CORES are never
// issued; such accesses are ignored.
module row_shadow_tracker #(
    parameter int NUM_CORES = 4,
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 20,
    parameter int MSHR_W    = 4,
    parameter int T_RP      = 9,
    parameter int T_RCD     = 9,
    parameter int PEN_W     = 8,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_page,
    input  logic              acc_valid,
    input  logic [CORE_W-1:0] acc_core,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic              acc_row_hit,
    input  logic [MSHR_W-1:0] acc_mshr,
    output logic              pen_valid,
    output logic [PEN_W-1:0]  pen_cycles,
    output logic [MSHR_W-1:0] pen_mshr
);
    import orow_pkg::*;

    localparam int                PEN      = T_RP + T_RCD;
    localparam logic [CORE_W:0]   CORE_LIM = (CORE_W+1)'(NUM_CORES);

    page_policy_e      policy;
    logic              core_ok;
    logic              upd_en;
    logic              sel_valid;
    logic [ROW_W-1:0]  sel_row;
    logic              interfere;
    logic [NUM_CORES-1:0] tbl_valid;
    logic [ROW_W-1:0]     tbl_row [NUM_CORES];

    // Policy decode and core range guard.
    always_comb begin
        policy  = page_policy_e'(open_page);
        core_ok = {1'b0, acc_core} < CORE_LIM;
        upd_en  = acc_valid && core_ok && (policy == PAGE_OPEN);
    end

    // One shadow table per core; only the issuing core's table is written.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        orow_bank_table #(
            .NUM_BANKS (NUM_BANKS),
            .ROW_W     (ROW_W),
            .BANK_W    (BANK_W)
        ) i_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (upd_en && (acc_core == CORE_W'(g))),
            .bank     (acc_bank),
            .wr_row   (acc_row),
            .rd_valid (tbl_valid[g]),
            .rd_row   (tbl_row[g])
        );
    end

    // Select the issuing core's entry for classification.
    always_comb begin
        sel_valid = 1'b0;
        sel_row   = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (acc_core == CORE_W'(c)) begin
                sel_valid = tbl_valid[c];
                sel_row   = tbl_row[c];
            end
        end
    end

    orow_classifier #(
        .ROW_W (ROW_W)
    ) i_class (
        .acc_valid   (acc_valid && core_ok),
        .policy_open (policy == PAGE_OPEN),
        .row_hit     (acc_row_hit),
        .entry_valid (sel_valid),
        .entry_row   (sel_row),
        .acc_row     (acc_row),
        .interfere   (interfere)
    );

    orow_penalty_reg #(
        .MSHR_W (MSHR_W),
        .PEN_W  (PEN_W),
        .PEN    (PEN)
    ) i_pen (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (interfere),
        .mshr_in    (acc_mshr),
        .pen_valid  (pen_valid),
        .pen_cycles (pen_cycles),
        .pen_mshr   (pen_mshr)
    );
endmodule

// File: rtl/orow_checker.sv
// Module: protocol checker bound to the tracker top.
// Assumes: the same parameters as the bound instance.
module orow_checker #(
    parameter int CORE_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 20,
    parameter int MSHR_W = 4,
    parameter int PEN_W  = 8,
    parameter int PEN    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              open_page,
    input logic              acc_valid,
    input logic              acc_row_hit,
    input logic [MSHR_W-1:0] acc_mshr,
    input logic              pen_valid,
    input logic [PEN_W-1:0]  pen_cycles,
    input logic [MSHR_W-1:0] pen_mshr
);
    AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        pen_valid |-> $past(acc_valid)); // R8
    AST_NO_CHARGE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pen_valid |-> !$past(acc_row_hit)); // R3
    AST_CLOSED_PAGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        pen_valid |-> $past(open_page)); // R7
    AST_PENALTY_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        pen_valid |-> (pen_cycles == PEN_W'(PEN))); // R2
    AST_MSHR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        pen_valid |-> (pen_mshr == $past(acc_mshr))); // R2
endmodule

bind row_shadow_tracker orow_checker #(
    .CORE_W (CORE_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .MSHR_W (MSHR_W),
    .PEN_W  (PEN_W),
    .PEN    (T_RP + T_RCD)
) i_orow_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_page   (open_page),
    .acc_valid   (acc_valid),
    .acc_row_hit (acc_row_hit),
    .acc_mshr    (acc_mshr),
    .pen_valid   (pen_valid),
    .pen_cycles  (pen_cycles),
    .pen_mshr    (pen_mshr)
);

// File: tb/test_row_shadow_tracker.sv
// Bench: sweeps all cores and banks against an arithmetic model.
module test_row_shadow_tracker;
    localparam int NC = 4, NB = 8, RW = 20, MW = 4, PW = 8, CW = 2, BW = 3;
    localparam int EXP_PEN = 9 + 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          open_page = 1'b1;
    logic          acc_valid = 1'b0;
    logic [CW-1:0] acc_core = '0;
    logic [BW-1:0] acc_bank = '0;
    logic [RW-1:0] acc_row = '0;
    logic          acc_row_hit = 1'b0;
    logic [MW-1:0] acc_mshr = '0;
    logic          pen_valid;
    logic [PW-1:0] pen_cycles;
    logic [MW-1:0] pen_mshr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit            m_vld [NC][NB];
    logic [RW-1:0] m_row [NC][NB];

    always #2.5 clk = ~clk;

    row_shadow_tracker i_row_shadow_tracker (
        .clk(clk), .rst_n(rst_n), .open_page(open_page), .acc_valid(acc_valid),
        .acc_core(acc_core), .acc_bank(acc_bank), .acc_row(acc_row),
        .acc_row_hit(acc_row_hit), .acc_mshr(acc_mshr), .pen_valid(pen_valid),
        .pen_cycles(pen_cycles), .pen_mshr(pen_mshr)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; the expected charge comes from the requirement model.
    task automatic access(input string req, input int c, input int b,
                          input int row, input bit hit, input int mshr);
        bit exp_chg;
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_core    = CW'(c);
        acc_bank    = BW'(b);
        acc_row     = RW'(row);
        acc_row_hit = hit;
        acc_mshr    = MW'(mshr);
        exp_chg = open_page && !hit && m_vld[c][b] && (m_row[c][b] == RW'(row));
        if (open_page) begin
            m_vld[c][b] = 1'b1;
            m_row[c][b] = RW'(row);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        check(req, int'(pen_valid), int'(exp_chg));
        if (exp_chg) begin
            check({req, " value"}, int'(pen_cycles), EXP_PEN);
            check({req, " mshr"}, int'(pen_mshr), mshr);
        end
    endtask

    initial begin
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++) begin
                m_vld[c][b] = 1'b0;
                m_row[c][b] = '0;
            end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset strobe", int'(pen_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Main sweep over every core and bank.
        for (int c = 0; c < NC; c++) begin
            for (int b = 0; b < NB; b++) begin
                int r0 = 'h1000 + c * 64 + b;
                int oc = (c + 1) % NC;
                access("R1 empty entry miss", c, b, r0, 1'b0, (c + b) % 16);
                access("R3 hit no charge", c, b, r0, 1'b1, 3);
                access("R6 other core writes", oc, b, r0 + 'h777, 1'b0, 5);
                access("R2 interference charge", c, b, r0, 1'b0, (c * 3 + b) % 16);
                access("R4 different row", c, b, r0 + 1, 1'b0, 7);
                access("R5 update after miss", c, b, r0 + 1, 1'b0, 9);
                access("R5 hit updates", c, b, r0 + 2, 1'b1, 2);
                access("R5 charge after hit update", c, b, r0 + 2, 1'b0, 11);
            end
        end

        // Bank independence: write bank 0, bank 1 entry keeps its row.
        access("R9 set bank1", 2, 1, 'hABCDE, 1'b0, 1);
        access("R9 other bank", 2, 0, 'h12345, 1'b0, 1);
        access("R9 bank1 kept", 2, 1, 'hABCDE, 1'b0, 14);

        // Closed-page: no charge and no learning.
        access("R7 learn", 1, 4, 'h0F0F0, 1'b0, 0);
        open_page = 1'b0;
        access("R7 closed no charge", 1, 4, 'h0F0F0, 1'b0, 6);
        access("R7 closed no update", 1, 4, 'h55555, 1'b0, 6);
        open_page = 1'b1;
        access("R7 entry unchanged", 1, 4, 'h0F0F0, 1'b0, 13);

        // Idle cycle: strobe drops without an access.
        @(posedge clk);
        #1;
        check("R8 idle no strobe", int'(pen_valid), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule